// File: doc/BRIEF.md
# Tiled Aperture Fence Register Bank

This block keeps a small, fixed set of fence descriptors. Each descriptor marks one page-aligned window of a linear graphics aperture as tiled, and records that window's tiling layout (X or Y) and its row pitch. A host fills the descriptors through a 32-bit write port. Every 64-bit descriptor is reached as two words: a low word that carries the start page, pitch, layout and an enable flag, and a high word that carries the last page of the window.

On the lookup side a client presents an aperture page number. One clock later the block reports four things: whether an enabled fence covers that page, which fence covers it, that fence's layout, and its pitch in bytes. The host must retire a fence before rewriting it: write the low word to zero, then write the high word, then write the low word with the enable flag set. A sticky error flag reports a high-word write that lands on an enabled fence, because such a write would expose a half-written window to lookups.

Top module: `fence_bank`

## Requirements
- R1: A low-word write to fence k stores the start page from bits [31:12], the pitch field from bits [11:2], the layout from bit 1 (1 = Y, 0 = X) and the enable flag from bit 0. The new contents take part in lookups presented from the next clock on.
- R2: A high-word write to fence k stores bits [31:12] as the last page of the window, inclusive.
- R3: A lookup hits fence k only when k is enabled and start page <= lookup page <= last page. A fence whose last page is below its start page matches nothing.
- R4: When several fences match, the result reports the lowest matching index.
- R5: The lookup result is registered: it reflects the page that was presented at the previous rising clock edge.
- R6: On a hit the pitch output equals (pitch field + 1) * 128 bytes, and the layout output is 1 for Y and 0 for X.
- R7: On a miss the hit output is 0 and the index, layout and pitch outputs are all 0.
- R8: A fence with its enable flag clear never matches. Writing its low word with bit 0 clear retires only that fence, and throughout the zero, high-word, enable sequence the fence does not match until the final low-word write.
- R9: A high-word write to a fence whose enable flag is set raises the error flag. The flag stays set until reset, and the legal update sequence never raises it.
- R10: Synchronous reset disables every fence and clears the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_hi | input | 1 | Word select: 1 = high word, 0 = low word |
| host_idx | input | IDX_W | Fence number being written |
| host_wdata | input | 32 | Host write data |
| lk_page | input | PG_W | Aperture page number to look up |
| lk_hit | output | 1 | A fence covers the page (registered) |
| lk_idx | output | IDX_W | Lowest matching fence index |
| lk_y | output | 1 | Layout of matching fence: 1 = Y, 0 = X |
| lk_pitch | output | PITCH_W+8 | Pitch of matching fence in bytes |
| prot_err | output | 1 | Sticky protocol error flag |

## Verification
The hardest condition to reach from the ports is a fence caught in the middle of its update sequence. That state exists only between the zeroing low-word write and the enabling low-word write, so the bench stops after each step and looks up a page inside the old window. Overlapping windows and an inverted window (last page below start) are loaded on purpose to exercise the priority and range comparisons. The illegal high-word write is issued on a live fence, followed by legal writes, to show that the error flag stays set.

// File: rtl/fence_pkg.sv
package fence_pkg;
  // Low-word field positions; the lookup decoder depends on them.
  localparam int LO_EN_BIT    = 0;
  localparam int LO_Y_BIT     = 1;
  localparam int LO_PITCH_LSB = 2;

  typedef enum logic {
    LAYOUT_X = 1'b0,
    LAYOUT_Y = 1'b1
  } layout_e;
endpackage

// File: rtl/fence_store.sv
module fence_store #(
  parameter int NUM_FENCES = 16,
  parameter int WORD_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int PITCH_W    = 10,
  localparam int IDX_W     = (NUM_FENCES > 1) ? $clog2(NUM_FENCES) : 1,
  localparam int PG_W      = WORD_W - PAGE_SHIFT
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                host_we,
  input  logic                                host_hi,
  input  logic [IDX_W-1:0]                    host_idx,
  input  logic [WORD_W-1:0]                   host_wdata,
  output logic [NUM_FENCES-1:0][PG_W-1:0]     start_pg,
  output logic [NUM_FENCES-1:0][PG_W-1:0]     last_pg,
  output logic [NUM_FENCES-1:0][PITCH_W-1:0]  pitch_fld,
  output logic [NUM_FENCES-1:0]               layout,
  output logic [NUM_FENCES-1:0]               en,
  output logic                                prot_err
);
  import fence_pkg::*;

  logic idx_ok;
  logic live_hit_write;

  assign idx_ok         = (int'(host_idx) < NUM_FENCES);
  assign live_hit_write = host_we && host_hi && idx_ok && en[host_idx];

  for (genvar k = 0; k < NUM_FENCES; k++) begin : g_fence
    logic sel;
    assign sel = host_we && idx_ok && (int'(host_idx) == k);

    always_ff @(posedge clk) begin
      if (rst) begin
        start_pg[k]  <= '0;
        last_pg[k]   <= '0;
        pitch_fld[k] <= '0;
        layout[k]    <= LAYOUT_X;
        en[k]        <= 1'b0;
      end else if (sel) begin
        if (host_hi) begin
          last_pg[k] <= host_wdata[WORD_W-1:PAGE_SHIFT];
        end else begin
          start_pg[k]  <= host_wdata[WORD_W-1:PAGE_SHIFT];
          pitch_fld[k] <= host_wdata[LO_PITCH_LSB +: PITCH_W];
          layout[k]    <= host_wdata[LO_Y_BIT];
          en[k]        <= host_wdata[LO_EN_BIT];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_err <= 1'b0;
    end else if (live_hit_write) begin
      prot_err <= 1'b1;
    end
  end
endmodule

// File: rtl/fence_match.sv
module fence_match #(
  parameter int NUM_FENCES = 16,
  parameter int PG_W       = 20,
  localparam int IDX_W     = (NUM_FENCES > 1) ? $clog2(NUM_FENCES) : 1
) (
  input  logic [PG_W-1:0]                  page,
  input  logic [NUM_FENCES-1:0][PG_W-1:0]  start_pg,
  input  logic [NUM_FENCES-1:0][PG_W-1:0]  last_pg,
  input  logic [NUM_FENCES-1:0]            en,
  output logic                             any_hit,
  output logic [IDX_W-1:0]                 win_idx
);
  logic [NUM_FENCES-1:0] hit_vec;

  for (genvar k = 0; k < NUM_FENCES; k++) begin : g_cmp
    assign hit_vec[k] = en[k] && (page >= start_pg[k]) && (page <= last_pg[k]);
  end

  // Walk from the top down so the lowest matching index is kept last.
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int k = NUM_FENCES - 1; k >= 0; k--) begin
      if (hit_vec[k]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/fence_result.sv
module fence_result #(
  parameter int NUM_FENCES = 16,
  parameter int PITCH_W    = 10,
  localparam int IDX_W     = (NUM_FENCES > 1) ? $clog2(NUM_FENCES) : 1,
  localparam int PB_W      = PITCH_W + 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               any_hit,
  input  logic [IDX_W-1:0]                   win_idx,
  input  logic [NUM_FENCES-1:0][PITCH_W-1:0] pitch_fld,
  input  logic [NUM_FENCES-1:0]              layout,
  output logic                               lk_hit,
  output logic [IDX_W-1:0]                   lk_idx,
  output logic                               lk_y,
  output logic [PB_W-1:0]                    lk_pitch
);
  logic [PITCH_W-1:0] fld;
  logic [PB_W-1:0]    bytes;
  logic               y_sel;

  always_comb begin
    fld   = pitch_fld[win_idx];
    y_sel = layout[win_idx];
    bytes = (PB_W'(fld) + PB_W'(1)) << 7;
  end

  always_ff @(posedge clk) begin
    if (rst || !any_hit) begin
      lk_hit   <= 1'b0;
      lk_idx   <= '0;
      lk_y     <= 1'b0;
      lk_pitch <= '0;
    end else begin
      lk_hit   <= 1'b1;
      lk_idx   <= win_idx;
      lk_y     <= y_sel;
      lk_pitch <= bytes;
    end
  end
endmodule

// File: rtl/fence_bank.sv
module fence_bank #(
  parameter int NUM_FENCES = 16,
  parameter int WORD_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int PITCH_W    = 10,
  localparam int IDX_W     = (NUM_FENCES > 1) ? $clog2(NUM_FENCES) : 1,
  localparam int PG_W      = WORD_W - PAGE_SHIFT,
  localparam int PB_W      = PITCH_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_hi,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic [PG_W-1:0]   lk_page,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic              lk_y,
  output logic [PB_W-1:0]   lk_pitch,
  output logic              prot_err
);
  logic [NUM_FENCES-1:0][PG_W-1:0]    start_pg;
  logic [NUM_FENCES-1:0][PG_W-1:0]    last_pg;
  logic [NUM_FENCES-1:0][PITCH_W-1:0] pitch_fld;
  logic [NUM_FENCES-1:0]              layout;
  logic [NUM_FENCES-1:0]              fence_en;
  logic                               any_hit;
  logic [IDX_W-1:0]                   win_idx;

  fence_store #(
    .NUM_FENCES(NUM_FENCES), .WORD_W(WORD_W),
    .PAGE_SHIFT(PAGE_SHIFT), .PITCH_W(PITCH_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_hi(host_hi),
    .host_idx(host_idx), .host_wdata(host_wdata),
    .start_pg(start_pg), .last_pg(last_pg),
    .pitch_fld(pitch_fld), .layout(layout),
    .en(fence_en), .prot_err(prot_err)
  );

  fence_match #(
    .NUM_FENCES(NUM_FENCES), .PG_W(PG_W)
  ) u_match (
    .page(lk_page), .start_pg(start_pg), .last_pg(last_pg),
    .en(fence_en), .any_hit(any_hit), .win_idx(win_idx)
  );

  fence_result #(
    .NUM_FENCES(NUM_FENCES), .PITCH_W(PITCH_W)
  ) u_result (
    .clk(clk), .rst(rst),
    .any_hit(any_hit), .win_idx(win_idx),
    .pitch_fld(pitch_fld), .layout(layout),
    .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_y(lk_y), .lk_pitch(lk_pitch)
  );
endmodule

// File: rtl/fence_bank_chk.sv
module fence_bank_chk #(
  parameter int NUM_FENCES = 16,
  parameter int PITCH_W    = 10,
  localparam int IDX_W     = (NUM_FENCES > 1) ? $clog2(NUM_FENCES) : 1,
  localparam int PB_W      = PITCH_W + 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  host_we,
  input logic                  host_hi,
  input logic [IDX_W-1:0]      host_idx,
  input logic [NUM_FENCES-1:0] fence_en,
  input logic                  lk_hit,
  input logic [IDX_W-1:0]      lk_idx,
  input logic                  lk_y,
  input logic [PB_W-1:0]       lk_pitch,
  input logic                  prot_err
);
  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!lk_hit && !prot_err));

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_idx == '0 && !lk_y && lk_pitch == '0));

  assert_pitch_units_R6: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_pitch[6:0] == 7'd0 && lk_pitch != '0));

  assert_err_raise_R9: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_hi && fence_en[host_idx]) |=> prot_err);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    prot_err |=> prot_err);

  assert_none_enabled_R8: assert property (@(posedge clk) disable iff (rst)
    (fence_en == '0) |=> !lk_hit);
endmodule

bind fence_bank fence_bank_chk #(
  .NUM_FENCES(NUM_FENCES), .PITCH_W(PITCH_W)
) u_chk (
  .clk(clk), .rst(rst),
  .host_we(host_we), .host_hi(host_hi), .host_idx(host_idx),
  .fence_en(fence_en),
  .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_y(lk_y), .lk_pitch(lk_pitch),
  .prot_err(prot_err)
);

// File: tb/sim_fence_bank.sv
`timescale 1ns/1ps
module sim_fence_bank;
  localparam int N   = 16;
  localparam int IW  = 4;
  localparam int PGW = 20;
  localparam int PBW = 18;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           host_we = 1'b0;
  logic           host_hi = 1'b0;
  logic [IW-1:0]  host_idx = '0;
  logic [31:0]    host_wdata = '0;
  logic [PGW-1:0] lk_page = '0;
  logic           lk_hit, lk_y, prot_err;
  logic [IW-1:0]  lk_idx;
  logic [PBW-1:0] lk_pitch;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fence_bank #(.NUM_FENCES(N)) u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_hi(host_hi),
    .host_idx(host_idx), .host_wdata(host_wdata), .lk_page(lk_page),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_y(lk_y),
    .lk_pitch(lk_pitch), .prot_err(prot_err)
  );

  // {page[19:0], hit, idx[3:0], y, pitch_bytes[17:0]}
  localparam int VW = 44;
  localparam logic [VW-1:0] VEC [10] = '{
    {20'h000FF, 1'b0, 4'd0,  1'b0, 18'd0},      // R3 below every window
    {20'h00100, 1'b1, 4'd2,  1'b0, 18'd512},    // R1 R3 start page inclusive
    {20'h00103, 1'b1, 4'd2,  1'b0, 18'd512},    // R4 overlap, lower index wins
    {20'h00104, 1'b1, 4'd7,  1'b1, 18'd1024},   // R6 Y layout
    {20'h00108, 1'b1, 4'd7,  1'b1, 18'd1024},   // R2 last page inclusive
    {20'h00109, 1'b0, 4'd0,  1'b0, 18'd0},      // R7 past last page
    {20'h00200, 1'b1, 4'd5,  1'b1, 18'd128},    // R6 minimum pitch
    {20'h00201, 1'b0, 4'd0,  1'b0, 18'd0},      // R2 single page window
    {20'h00300, 1'b0, 4'd0,  1'b0, 18'd0},      // R3 inverted window
    {20'hFFFFF, 1'b1, 4'd15, 1'b0, 18'd131072}  // R6 maximum pitch
  };

  function automatic logic [31:0] lo_word(logic [31:0] start, int fld, bit y, bit en);
    return {start[31:12], 10'(fld), y, en};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, bit hi, logic [31:0] data);
    @(negedge clk);
    host_we = 1'b1; host_hi = hi; host_idx = IW'(idx); host_wdata = data;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic look(logic [PGW-1:0] pg);
    @(negedge clk);
    lk_page = pg;
    @(negedge clk);
  endtask

  task automatic expect_res(string tag, bit hit, int idx, bit y, int pb);
    check({tag, " hit"},   32'(lk_hit),   32'(hit));
    check({tag, " idx"},   32'(lk_idx),   32'(idx));
    check({tag, " y"},     32'(lk_y),     32'(y));
    check({tag, " pitch"}, 32'(lk_pitch), 32'(pb));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 hit after reset", 32'(lk_hit), 0);
    check("R10 err after reset", 32'(prot_err), 0);
    look(20'h00100);
    expect_res("R10 no fence after reset", 0, 0, 0, 0);

    // Load fences using the legal sequence (R9: no error expected).
    wr(2, 0, 0); wr(2, 1, 32'h0010_3000); wr(2, 0, lo_word(32'h0010_0000, 3, 0, 1));
    wr(7, 0, 0); wr(7, 1, 32'h0010_8000); wr(7, 0, lo_word(32'h0010_2000, 7, 1, 1));
    wr(5, 0, 0); wr(5, 1, 32'h0020_0000); wr(5, 0, lo_word(32'h0020_0000, 0, 1, 1));
    wr(3, 0, 0); wr(3, 1, 32'h002F_F000); wr(3, 0, lo_word(32'h0030_0000, 1, 0, 1));
    wr(15, 0, 0); wr(15, 1, 32'hFFFF_F000); wr(15, 0, lo_word(32'hFFFF_F000, 1023, 0, 1));
    check("R9 legal sequence leaves error clear", 32'(prot_err), 0);

    for (int i = 0; i < 10; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      look(v[43:24]);
      expect_res($sformatf("R3 R4 R6 vector %0d", i),
                 v[23], int'(v[22:19]), v[18], int'(v[17:0]));
    end

    // R5: result reflects the page presented at the previous edge.
    @(negedge clk); lk_page = 20'h00200;
    @(negedge clk); lk_page = 20'h00109;
    check("R5 registered result idx", 32'(lk_idx), 5);
    @(negedge clk);
    check("R5 next result miss", 32'(lk_hit), 0);

    // R8: mid-update fence 5 does not match.
    wr(5, 0, 0);
    look(20'h00200);
    expect_res("R8 after zero low word", 0, 0, 0, 0);
    wr(5, 1, 32'h0020_1000);
    look(20'h00201);
    expect_res("R8 after high word", 0, 0, 0, 0);
    wr(5, 0, lo_word(32'h0020_0000, 2, 0, 1));
    look(20'h00201);
    expect_res("R1 re-enabled fence", 1, 5, 0, 384);
    check("R9 legal update no error", 32'(prot_err), 0);

    // R8: retiring fence 2 alone exposes fence 7 on the overlap.
    wr(2, 0, lo_word(32'h0010_0000, 3, 0, 0));
    look(20'h00102);
    expect_res("R8 retire one fence", 1, 7, 1, 1024);
    look(20'h00100);
    expect_res("R8 retired fence miss", 0, 0, 0, 0);

    // R9: high word written on a live fence.
    wr(7, 1, 32'h0010_9000);
    check("R9 error raised", 32'(prot_err), 1);
    wr(7, 0, 0);
    wr(7, 1, 32'h0010_9000);
    check("R9 error sticky", 32'(prot_err), 1);

    // R10: reset clears fences and flag.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 error cleared", 32'(prot_err), 0);
    look(20'hFFFFF);
    expect_res("R10 fences cleared", 0, 0, 0, 0);

    finish_run();
  end
endmodule